// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Controller

This block collects interrupt requests from twelve maskable peripheral sources in a small 8-bit microcontroller. The sources are four external pins, four timers, an analog converter, a watchdog, an interval timer and a serial port. A one-cycle event pulse from a source latches a sticky request flag. Each flag is masked by a per-source enable bit, and all sources are gated together by one global enable. Software reaches the enables and the flags through a byte-wide register port.

Among the sources that are pending and enabled, the block selects the one with the highest fixed rank. While the global enable is set, it raises a request to the CPU together with a 16-bit vector address. When the CPU acknowledges, the global enable drops, so no further request is raised until software turns it back on. The flags themselves are never cleared by hardware. Software clears them by writing zeros.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset, all four registers read 0x00, the global enable `gie_o` is 0 and `irq_req_o` is 0.
- R2: An event pulse on source k sets flag k at the next clock edge. The flag stays set through idle cycles and through acknowledge until software writes 0 to it.
- R3: If an event and a software write of 0 reach the same flag in the same cycle, the flag ends up set.
- R4: Sources are indexed 0 to 11 as INT0, INT1, T0, T1, INT2, INT3, T2, T3, ADC, WDT, interval timer, serial. The enable registers sit at 0xE2 and 0xE3 and the flag registers at 0xE4 and 0xE5. In 0xE2 and 0xE4, source k (0..7) sits at bit 7-k. In 0xE3 and 0xE5, source k (8..11) sits at bit 15-k. All of these bits read back what was written.
- R5: Bits 3..0 of 0xE3 and 0xE5 always read 0, and writes to them have no effect. An address outside 0xE2..0xE5 reads 0x00.
- R6: `irq_req_o` is 1 exactly when `gie_o` is 1 and at least one source has both its flag and its enable set.
- R7: When several sources are pending and enabled, the one with the lowest index wins.
- R8: `irq_vec_o` equals 0xFFFA − 2·k for the winning source k, from 0xFFFA (INT0) down to 0xFFE4 (serial).
- R9: A cycle with `irq_ack_i` high makes `gie_o` 0 from the next edge onward, which drops `irq_req_o`. The flags are left unchanged.
- R10: `gie_set_i` sets the global enable. `gie_clr_i` or `irq_ack_i` clears it, and either one overrides a set in the same cycle. With none of the three high, the enable holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 12 | One-cycle event pulses, index = source number |
| bus_sel_i | input | 1 | Register port select |
| bus_we_i | input | 1 | Register write strobe (with select) |
| bus_addr_i | input | 8 | Register address |
| bus_wdata_i | input | 8 | Register write data |
| bus_rdata_o | output | 8 | Register read data (combinational, 0 when not selected) |
| gie_set_i | input | 1 | Set global enable |
| gie_clr_i | input | 1 | Clear global enable |
| irq_ack_i | input | 1 | CPU acknowledge |
| irq_req_o | output | 1 | Interrupt request to CPU |
| irq_vec_o | output | 16 | Vector address of the winning source |
| gie_o | output | 1 | Current global enable |

## Verification
The hardest case to reach is a software clear and a hardware event landing on the same flag in the same clock cycle. The bench drives the event pulse and the flag-register write from the same falling edge, so both are seen at one rising edge, and then reads the flag back. The priority logic is swept over every pair of pending sources and over a stride of enable masks. Each expected vector is computed in the bench from the lowest set index.

// File: rtl/irq_pkg.sv
package irq_pkg;
   // command applied to the global enable in one cycle
   typedef enum logic [1:0] {
      GIE_HOLD = 2'd0,
      GIE_SET  = 2'd1,
      GIE_CLR  = 2'd2
   } gie_cmd_e;

   // register bank that holds a given source
   function automatic int src_bank(input int src, input int dw);
      return src / dw;
   endfunction

   // bit position of a source inside its bank (first source at the MSB)
   function automatic int src_bit(input int src, input int dw);
      return dw - 1 - (src % dw);
   endfunction
endpackage

// File: rtl/irq_regfile.sv
module irq_regfile #(
   parameter int NUM_SRC   = 12,
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 8,
   parameter int EN_BASE   = 'hE2,
   parameter int FLAG_BASE = 'hE4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_sel_i,
   input  logic               bus_we_i,
   input  logic [ADDR_W-1:0]  bus_addr_i,
   input  logic [DATA_W-1:0]  bus_wdata_i,
   output logic [DATA_W-1:0]  bus_rdata_o,
   input  logic [NUM_SRC-1:0] evt_i,
   output logic [NUM_SRC-1:0] en_q,
   output logic [NUM_SRC-1:0] flag_q
);
   import irq_pkg::*;

   logic wr_stb;
   assign wr_stb = bus_sel_i && bus_we_i;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      localparam int BK = src_bank(i, DATA_W);
      localparam int BT = src_bit(i, DATA_W);
      localparam logic [ADDR_W-1:0] EN_A = ADDR_W'(EN_BASE + BK);
      localparam logic [ADDR_W-1:0] FL_A = ADDR_W'(FLAG_BASE + BK);
      logic en_wr, fl_wr;
      assign en_wr = wr_stb && (bus_addr_i == EN_A);
      assign fl_wr = wr_stb && (bus_addr_i == FL_A);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      en_q[i] <= 1'b0;
         else if (en_wr)  en_q[i] <= bus_wdata_i[BT];
      end

      // a hardware event takes precedence over a software write
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         flag_q[i] <= 1'b0;
         else if (evt_i[i])  flag_q[i] <= 1'b1;
         else if (fl_wr)     flag_q[i] <= bus_wdata_i[BT];
      end
   end

   // unimplemented positions and unmapped addresses read as zero
   always_comb begin
      bus_rdata_o = '0;
      if (bus_sel_i) begin
         for (int i = 0; i < NUM_SRC; i++) begin
            if (bus_addr_i == ADDR_W'(EN_BASE + src_bank(i, DATA_W)))
               bus_rdata_o[src_bit(i, DATA_W)] = en_q[i];
            if (bus_addr_i == ADDR_W'(FLAG_BASE + src_bank(i, DATA_W)))
               bus_rdata_o[src_bit(i, DATA_W)] = flag_q[i];
         end
      end
   end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
   parameter int N         = 12,
   parameter bit ENC_ARITH = 1'b0,
   localparam int IDX_W    = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]     req_i,
   output logic             any_o,
   output logic [IDX_W-1:0] idx_o
);
   assign any_o = |req_i;

   if (ENC_ARITH) begin : g_arith
      // isolate lowest set bit, then OR-encode its position
      logic [N-1:0] onehot;
      assign onehot = req_i & (~req_i + N'(1));
      always_comb begin
         idx_o = '0;
         for (int i = 0; i < N; i++)
            if (onehot[i]) idx_o = idx_o | IDX_W'(i);
      end
   end else begin : g_chain
      // scan from lowest rank to highest; the last hit is the winner
      always_comb begin
         idx_o = '0;
         for (int i = N - 1; i >= 0; i--)
            if (req_i[i]) idx_o = IDX_W'(i);
      end
   end
endmodule

// File: rtl/irq_vec_gen.sv
module irq_vec_gen #(
   parameter int N        = 12,
   parameter int VEC_W    = 16,
   parameter int VEC_TOP  = 'hFFFA,
   parameter int VEC_STEP = 2,
   localparam int IDX_W   = (N > 1) ? $clog2(N) : 1
) (
   input  logic [IDX_W-1:0] idx_i,
   output logic [VEC_W-1:0] vec_o
);
   localparam logic [VEC_W-1:0] TOP = VEC_W'(VEC_TOP);

   if (VEC_STEP == 2) begin : g_shift
      assign vec_o = TOP - {{(VEC_W-IDX_W-1){1'b0}}, idx_i, 1'b0};
   end else begin : g_mul
      assign vec_o = TOP - VEC_W'(idx_i) * VEC_W'(VEC_STEP);
   end
endmodule

// File: rtl/irq_gie.sv
module irq_gie (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   input  logic ack_i,
   output logic gie_o
);
   import irq_pkg::*;

   gie_cmd_e cmd;

   always_comb begin
      if (clr_i || ack_i)  cmd = GIE_CLR;
      else if (set_i)      cmd = GIE_SET;
      else                 cmd = GIE_HOLD;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gie_o <= 1'b0;
      else begin
         case (cmd)
            GIE_SET: gie_o <= 1'b1;
            GIE_CLR: gie_o <= 1'b0;
            default: gie_o <= gie_o;
         endcase
      end
   end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl #(
   parameter int NUM_SRC   = 12,
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 8,
   parameter int VEC_W     = 16,
   parameter int EN_BASE   = 'hE2,
   parameter int FLAG_BASE = 'hE4,
   parameter int VEC_TOP   = 'hFFFA,
   parameter int VEC_STEP  = 2,
   parameter bit ENC_ARITH = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] evt_i,
   input  logic               bus_sel_i,
   input  logic               bus_we_i,
   input  logic [ADDR_W-1:0]  bus_addr_i,
   input  logic [DATA_W-1:0]  bus_wdata_i,
   output logic [DATA_W-1:0]  bus_rdata_o,
   input  logic               gie_set_i,
   input  logic               gie_clr_i,
   input  logic               irq_ack_i,
   output logic               irq_req_o,
   output logic [VEC_W-1:0]   irq_vec_o,
   output logic               gie_o
);
   localparam int NBANK = (NUM_SRC + DATA_W - 1) / DATA_W;
   localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

   if (NUM_SRC < 1) begin : g_bad_n
      $error("NUM_SRC must be at least 1");
   end
   if (FLAG_BASE < EN_BASE + NBANK) begin : g_bad_map
      $error("flag registers overlap enable registers");
   end
   if (VEC_TOP < VEC_STEP * (NUM_SRC - 1)) begin : g_bad_vec
      $error("vector table runs below zero");
   end
   if (VEC_W <= IDX_W) begin : g_bad_vw
      $error("VEC_W too narrow");
   end

   logic [NUM_SRC-1:0] en_q;
   logic [NUM_SRC-1:0] flag_q;
   logic [NUM_SRC-1:0] pend;
   logic               any_pend;
   logic [IDX_W-1:0]   win_idx;

   irq_regfile #(
      .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
      .EN_BASE(EN_BASE), .FLAG_BASE(FLAG_BASE)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_sel_i(bus_sel_i), .bus_we_i(bus_we_i),
      .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
      .bus_rdata_o(bus_rdata_o),
      .evt_i(evt_i), .en_q(en_q), .flag_q(flag_q)
   );

   assign pend = flag_q & en_q;

   irq_prio_enc #(.N(NUM_SRC), .ENC_ARITH(ENC_ARITH)) u_enc (
      .req_i(pend), .any_o(any_pend), .idx_o(win_idx)
   );

   irq_vec_gen #(
      .N(NUM_SRC), .VEC_W(VEC_W), .VEC_TOP(VEC_TOP), .VEC_STEP(VEC_STEP)
   ) u_vec (
      .idx_i(win_idx), .vec_o(irq_vec_o)
   );

   irq_gie u_gie (
      .clk(clk), .rst_n(rst_n),
      .set_i(gie_set_i), .clr_i(gie_clr_i), .ack_i(irq_ack_i),
      .gie_o(gie_o)
   );

   assign irq_req_o = gie_o && any_pend;
endmodule

// File: rtl/irq_vec_ctrl_chk.sv
module irq_vec_ctrl_chk #(
   parameter int NUM_SRC = 12,
   parameter int VEC_W   = 16,
   parameter int VEC_TOP = 'hFFFA
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_SRC-1:0] evt_i,
   input logic               bus_sel_i,
   input logic               bus_we_i,
   input logic               gie_set_i,
   input logic               gie_clr_i,
   input logic               irq_ack_i,
   input logic               irq_req_o,
   input logic [VEC_W-1:0]   irq_vec_o,
   input logic               gie_o,
   input logic [NUM_SRC-1:0] en_q,
   input logic [NUM_SRC-1:0] flag_q
);
   // R9
   ack_clears_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack_i |=> !gie_o);

   // R6
   req_needs_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req_o |-> gie_o);

   // R6
   req_needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req_o |-> ((flag_q & en_q) != '0));

   // R2
   evt_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_i != '0) |=> ((flag_q & $past(evt_i)) == $past(evt_i)));

   // R2
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_sel_i && bus_we_i) |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

   // R8
   vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req_o |-> (!irq_vec_o[0] && irq_vec_o <= VEC_W'(VEC_TOP)));

   // R10
   gie_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(gie_set_i || gie_clr_i || irq_ack_i) |=> $stable(gie_o));

   // R10
   gie_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gie_set_i && !gie_clr_i && !irq_ack_i) |=> gie_o);
endmodule

bind irq_vec_ctrl irq_vec_ctrl_chk #(
   .NUM_SRC(NUM_SRC), .VEC_W(VEC_W), .VEC_TOP(VEC_TOP)
) u_chk (
   .clk(clk), .rst_n(rst_n), .evt_i(evt_i),
   .bus_sel_i(bus_sel_i), .bus_we_i(bus_we_i),
   .gie_set_i(gie_set_i), .gie_clr_i(gie_clr_i), .irq_ack_i(irq_ack_i),
   .irq_req_o(irq_req_o), .irq_vec_o(irq_vec_o), .gie_o(gie_o),
   .en_q(en_q), .flag_q(flag_q)
);

// File: tb/tb_irq_vec_ctrl.sv
module tb_irq_vec_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] evt_i = '0;
   logic        bus_sel_i = 1'b0, bus_we_i = 1'b0;
   logic [7:0]  bus_addr_i = '0, bus_wdata_i = '0;
   logic [7:0]  bus_rdata_o;
   logic        gie_set_i = 1'b0, gie_clr_i = 1'b0, irq_ack_i = 1'b0;
   logic        irq_req_o, gie_o;
   logic [15:0] irq_vec_o;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   irq_vec_ctrl dut (
      .clk(clk), .rst_n(rst_n), .evt_i(evt_i),
      .bus_sel_i(bus_sel_i), .bus_we_i(bus_we_i),
      .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
      .bus_rdata_o(bus_rdata_o),
      .gie_set_i(gie_set_i), .gie_clr_i(gie_clr_i), .irq_ack_i(irq_ack_i),
      .irq_req_o(irq_req_o), .irq_vec_o(irq_vec_o), .gie_o(gie_o)
   );

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      bus_sel_i = 1'b1; bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
      tick();
      bus_sel_i = 1'b0; bus_we_i = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      bus_sel_i = 1'b1; bus_we_i = 1'b0; bus_addr_i = a;
      #1 d = bus_rdata_o;
      bus_sel_i = 1'b0;
   endtask

   function automatic logic [7:0] hi_of(input logic [11:0] v);
      logic [7:0] r = '0;
      for (int i = 0; i < 8; i++) r[7-i] = v[i];
      return r;
   endfunction

   function automatic logic [7:0] lo_of(input logic [11:0] v);
      logic [7:0] r = '0;
      for (int i = 8; i < 12; i++) r[15-i] = v[i];
      return r;
   endfunction

   function automatic logic [15:0] exp_vec(input logic [11:0] p);
      for (int k = 0; k < 12; k++)
         if (p[k]) return 16'hFFFA - 16'(2 * k);
      return 16'hFFFA;
   endfunction

   task automatic set_flags(input logic [11:0] v);
      wr(8'hE4, hi_of(v));
      wr(8'hE5, lo_of(v));
   endtask

   task automatic set_en(input logic [11:0] v);
      wr(8'hE2, hi_of(v));
      wr(8'hE3, lo_of(v));
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      #(20 * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
      $finish;
   end

   initial begin
      logic [7:0] d;
      logic [11:0] fv;
      tick(); tick();
      rst_n = 1'b1;
      tick();

      // R1 reset state
      rd(8'hE2, d); check("R1 E2", 16'(d), 16'h00);
      rd(8'hE3, d); check("R1 E3", 16'(d), 16'h00);
      rd(8'hE4, d); check("R1 E4", 16'(d), 16'h00);
      rd(8'hE5, d); check("R1 E5", 16'(d), 16'h00);
      check("R1 gie", 16'(gie_o), 16'h0);
      check("R1 req", 16'(irq_req_o), 16'h0);

      // R4 readback, R5 unimplemented bits and unmapped addresses
      wr(8'hE2, 8'hA5); rd(8'hE2, d); check("R4 E2 rb", 16'(d), 16'hA5);
      wr(8'hE4, 8'h3C); rd(8'hE4, d); check("R4 E4 rb", 16'(d), 16'h3C);
      wr(8'hE3, 8'hFF); rd(8'hE3, d); check("R5 E3 low nibble", 16'(d), 16'hF0);
      wr(8'hE5, 8'h5F); rd(8'hE5, d); check("R5 E5 low nibble", 16'(d), 16'h50);
      rd(8'hE6, d); check("R5 unmapped E6", 16'(d), 16'h00);
      rd(8'hE1, d); check("R5 unmapped E1", 16'(d), 16'h00);
      set_flags('0); set_en('0);

      // R2 each event sets its own flag and it stays through idle cycles
      for (int k = 0; k < 12; k++) begin
         fv = 12'(1) << k;
         evt_i = fv; tick(); evt_i = '0;
         tick(); tick();
         rd(8'hE4, d); check("R2 E4 after evt", 16'(d), 16'(hi_of(fv)));
         rd(8'hE5, d); check("R2 E5 after evt", 16'(d), 16'(lo_of(fv)));
         set_flags('0);
         rd(k < 8 ? 8'hE4 : 8'hE5, d); check("R2 cleared by sw", 16'(d), 16'h00);
      end

      // R3 event beats simultaneous software clear
      set_flags(12'hFFF);
      evt_i = 12'h001;
      bus_sel_i = 1'b1; bus_we_i = 1'b1; bus_addr_i = 8'hE4; bus_wdata_i = 8'h00;
      tick();
      bus_sel_i = 1'b0; bus_we_i = 1'b0; evt_i = '0;
      rd(8'hE4, d); check("R3 INT0 collision", 16'(d), 16'h80);
      evt_i = 12'h400;
      bus_sel_i = 1'b1; bus_we_i = 1'b1; bus_addr_i = 8'hE5; bus_wdata_i = 8'h00;
      tick();
      bus_sel_i = 1'b0; bus_we_i = 1'b0; evt_i = '0;
      rd(8'hE5, d); check("R3 BIT collision", 16'(d), 16'h20);
      set_flags('0);

      // R6 three-way gating
      set_flags(12'h010); set_en(12'h010);
      check("R6 no gie", 16'(irq_req_o), 16'h0);
      gie_set_i = 1'b1; tick(); gie_set_i = 1'b0;
      check("R6 all set", 16'(irq_req_o), 16'h1);
      set_en(12'h020);
      check("R6 enable mismatch", 16'(irq_req_o), 16'h0);
      set_en(12'h010); set_flags('0);
      check("R6 no flag", 16'(irq_req_o), 16'h0);

      // R7 R8 every pair of pending sources
      set_en(12'hFFF);
      for (int i = 0; i < 12; i++) begin
         for (int j = 0; j < 12; j++) begin
            fv = (12'(1) << i) | (12'(1) << j);
            set_flags(fv);
            check("R7 pair req", 16'(irq_req_o), 16'h1);
            check("R8 pair vec", irq_vec_o, exp_vec(fv));
         end
      end

      // R6 R7 enable-mask stride with all flags pending
      set_flags(12'hFFF);
      for (int m = 0; m < 4096; m += 37) begin
         set_en(12'(m));
         check("R6 mask req", 16'(irq_req_o), 16'(m != 0));
         if (m != 0) check("R7 mask vec", irq_vec_o, exp_vec(12'(m)));
      end

      // R9 acknowledge drops gie, flags unchanged
      set_en(12'hFFF); set_flags(12'h900);
      check("R9 pre req", 16'(irq_req_o), 16'h1);
      check("R8 ADC vec", irq_vec_o, 16'hFFEA);
      irq_ack_i = 1'b1; tick(); irq_ack_i = 1'b0;
      check("R9 gie low", 16'(gie_o), 16'h0);
      check("R9 req low", 16'(irq_req_o), 16'h0);
      rd(8'hE4, d); check("R9 E4 kept", 16'(d), 16'h00);
      rd(8'hE5, d); check("R9 E5 kept", 16'(d), 16'h90);
      gie_set_i = 1'b1; tick(); gie_set_i = 1'b0;
      check("R9 req again", 16'(irq_req_o), 16'h1);

      // R10 set/clear interplay
      gie_set_i = 1'b1; gie_clr_i = 1'b1; tick(); gie_set_i = 1'b0; gie_clr_i = 1'b0;
      check("R10 clr beats set", 16'(gie_o), 16'h0);
      tick(); check("R10 hold low", 16'(gie_o), 16'h0);
      gie_set_i = 1'b1; tick(); gie_set_i = 1'b0;
      check("R10 set", 16'(gie_o), 16'h1);
      tick(); check("R10 hold high", 16'(gie_o), 16'h1);
      gie_set_i = 1'b1; irq_ack_i = 1'b1; tick(); gie_set_i = 1'b0; irq_ack_i = 1'b0;
      check("R10 ack beats set", 16'(gie_o), 16'h0);

      summary();
      $finish;
   end
endmodule